// File: doc/BRIEF.md
# Ethernet Receive Frame Length Checker

This block watches the byte stream of a receive path one frame at a time. The stream carries a valid strobe, a first-byte flag and a last-byte flag. The block counts the bytes of each frame and picks up the two-octet length/type field. When the last byte arrives it reports two verdicts. The first says whether the data-field size disagrees with a stated length. The second says whether the frame ran past a programmable size limit.

Two configuration inputs turn the checks on or off. One enables the length comparison. The other, a huge-frame enable, lifts the size limit so that the 16-bit maximum value is not used. While a frame is still arriving, a running oversize flag rises as soon as the frame passes the limit. A storage stage downstream can use it to stop writing early and truncate the frame. Configuration inputs are expected to stay stable for the whole of a frame.

Top module: `eth_rx_len_chk`

## Requirements
- R1: A beat is a cycle with `rx_valid` high. A beat with `rx_first` high begins a new frame as byte 1, even if the previous frame never ended, and discards all state of that earlier frame. Cycles with `rx_valid` low are not counted.
- R2: While `cfg_len_chk_en` is low, `err_len_mismatch` stays low whatever the length/type field holds.
- R3: The length/type field is bytes 13 and 14 of the frame, high octet first. With checking enabled and a field value from 46 to 1500, a mismatch is flagged exactly when (total bytes − 18) differs from the field.
- R4: With checking enabled and a field value below 46, a mismatch is flagged exactly when (total bytes − 18) differs from 46.
- R5: A field value of 0x0600 or more is a type, and no mismatch is flagged for it.
- R6: With checking enabled, a field value from 0x05DD to 0x05FF is always flagged as a mismatch.
- R7: With checking enabled, a frame that ends before its 14th byte is flagged as a mismatch.
- R8: With `cfg_huge_en` low, `err_oversize` is flagged when the frame's byte count exceeds `cfg_max_len`.
- R9: With `cfg_huge_en` high, `err_oversize` is never flagged and `oversize_run` never rises.
- R10: `oversize_run` goes high in the cycle after the beat that carries byte `cfg_max_len`+1 (huge-frame enable low). It stays high until the cycle after the last beat, where it is low again.
- R11: Both error outputs are high only in the single cycle after a last beat, and are low in every other cycle.
- R12: The byte count saturates at 65535. With `cfg_max_len` = 0xFFFF, a frame of more than 65535 bytes is not flagged as oversize.
- R13: After reset all three outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Byte beat strobe |
| rx_first | input | 1 | Beat carries the first byte of a frame |
| rx_last | input | 1 | Beat carries the last byte of a frame |
| rx_data | input | 8 | Received byte |
| cfg_len_chk_en | input | 1 | Enable the length/type comparison |
| cfg_huge_en | input | 1 | Accept frames of any size |
| cfg_max_len | input | 16 | Maximum frame size in bytes |
| err_len_mismatch | output | 1 | Length mismatch verdict, one cycle after the last beat |
| err_oversize | output | 1 | Oversize verdict, one cycle after the last beat |
| oversize_run | output | 1 | Frame has passed the size limit and is still arriving |

## Verification
Suppose the byte counter slips by one. The size verdict then flips for frames whose length sits exactly at `cfg_max_len` or one byte beyond it. The length verdict flips for a frame that is exactly 46+18 bytes long, and both effects appear one cycle after that frame's last beat. If the length field is latched at the wrong byte position, frames that carry a type value start to report mismatches. If the sticky oversize state is not cleared, the next short frame reports a false oversize at its end, and `oversize_run` is already high during its first bytes. Idle gaps inside a frame, aborted frames and a frame of more than 65535 bytes test the counting and saturation paths.

// File: rtl/eth_lc_pkg.sv
package eth_lc_pkg;

  localparam int unsigned LC_CNT_W      = 16;
  localparam int unsigned LC_FIELD_POS  = 12;
  localparam int unsigned LC_MAX_LEN    = 1500;
  localparam int unsigned LC_MIN_TYPE   = 1536;
  localparam int unsigned LC_MIN_DATA   = 46;
  localparam int unsigned LC_OVERHEAD   = 18;

  typedef enum logic [1:0] {
    FLD_LENGTH  = 2'd0,
    FLD_INVALID = 2'd1,
    FLD_TYPE    = 2'd2
  } fld_kind_e;

  function automatic fld_kind_e classify_field(input logic [15:0] v,
                                               input int unsigned max_len,
                                               input int unsigned min_type);
    if (32'(v) <= max_len)       return FLD_LENGTH;
    else if (32'(v) >= min_type) return FLD_TYPE;
    else                         return FLD_INVALID;
  endfunction

endpackage

// File: rtl/lc_byte_counter.sv
module lc_byte_counter #(
  parameter int unsigned CNT_W = eth_lc_pkg::LC_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             beat,
  input  logic             first,
  output logic [CNT_W-1:0] cnt_next
);

  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    if (first)                cnt_next = CNT_ONE;
    else if (cnt_q == CNT_TOP) cnt_next = cnt_q;
    else                      cnt_next = cnt_q + CNT_ONE;
  end

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (beat) cnt_q <= cnt_next;
  end

endmodule

// File: rtl/lc_field_capture.sv
module lc_field_capture #(
  parameter int unsigned CNT_W     = eth_lc_pkg::LC_CNT_W,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned FIELD_POS = eth_lc_pkg::LC_FIELD_POS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                beat,
  input  logic                first,
  input  logic [CNT_W-1:0]    cnt_next,
  input  logic [DATA_W-1:0]   data,
  output logic [2*DATA_W-1:0] fld_next,
  output logic                fld_vld_next
);

  localparam logic [CNT_W-1:0] POS_HI = CNT_W'(FIELD_POS + 1);
  localparam logic [CNT_W-1:0] POS_LO = CNT_W'(FIELD_POS + 2);

  logic [2*DATA_W-1:0] fld_q;
  logic                vld_q;
  logic                hit_hi;
  logic                hit_lo;

  assign hit_hi = beat && (cnt_next == POS_HI);
  assign hit_lo = beat && (cnt_next == POS_LO);

  always_comb begin
    fld_next     = fld_q;
    fld_vld_next = vld_q && !(beat && first);
    if (hit_hi) fld_next[2*DATA_W-1:DATA_W] = data;
    if (hit_lo) begin
      fld_next[DATA_W-1:0] = data;
      fld_vld_next         = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fld_q <= '0;
      vld_q <= 1'b0;
    end else if (beat) begin
      fld_q <= fld_next;
      vld_q <= fld_vld_next;
    end
  end

endmodule

// File: rtl/lc_len_judge.sv
module lc_len_judge #(
  parameter int unsigned CNT_W     = eth_lc_pkg::LC_CNT_W,
  parameter int unsigned MAX_LEN   = eth_lc_pkg::LC_MAX_LEN,
  parameter int unsigned MIN_TYPE  = eth_lc_pkg::LC_MIN_TYPE,
  parameter int unsigned MIN_DATA  = eth_lc_pkg::LC_MIN_DATA,
  parameter int unsigned OVERHEAD  = eth_lc_pkg::LC_OVERHEAD
) (
  input  logic             enable,
  input  logic [15:0]      fld,
  input  logic             fld_vld,
  input  logic [CNT_W-1:0] total,
  output logic             mismatch
);
  import eth_lc_pkg::*;

  localparam int unsigned SUM_W = (CNT_W > 16 ? CNT_W : 16) + 1;

  fld_kind_e        kind;
  logic [SUM_W-1:0] want_total;
  logic [15:0]      data_len;

  always_comb begin
    kind       = classify_field(fld, MAX_LEN, MIN_TYPE);
    data_len   = (32'(fld) < MIN_DATA) ? 16'(MIN_DATA) : fld;
    want_total = SUM_W'(data_len) + SUM_W'(OVERHEAD);
    mismatch   = 1'b0;
    if (enable) begin
      if (!fld_vld) begin
        mismatch = 1'b1;
      end else begin
        unique case (kind)
          FLD_LENGTH:  mismatch = (SUM_W'(total) != want_total);
          FLD_INVALID: mismatch = 1'b1;
          default:     mismatch = 1'b0;
        endcase
      end
    end
  end

endmodule

// File: rtl/lc_size_guard.sv
module lc_size_guard #(
  parameter int unsigned CNT_W = eth_lc_pkg::LC_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             beat,
  input  logic             first,
  input  logic             last,
  input  logic             huge_en,
  input  logic [CNT_W-1:0] max_len,
  input  logic [CNT_W-1:0] cnt_next,
  output logic             over_end,
  output logic             run_flag
);

  logic over_q;
  logic over_now;

  assign over_now = !huge_en && (cnt_next > max_len);
  assign over_end = over_now || (over_q && !first);
  assign run_flag = over_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      over_q <= 1'b0;
    end else if (beat) begin
      if (last)       over_q <= 1'b0;
      else if (first) over_q <= over_now;
      else            over_q <= over_q || over_now;
    end
  end

endmodule

// File: rtl/eth_rx_len_chk.sv
module eth_rx_len_chk #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CNT_W     = eth_lc_pkg::LC_CNT_W,
  parameter int unsigned FIELD_POS = eth_lc_pkg::LC_FIELD_POS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic              rx_first,
  input  logic              rx_last,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              cfg_len_chk_en,
  input  logic              cfg_huge_en,
  input  logic [15:0]       cfg_max_len,
  output logic              err_len_mismatch,
  output logic              err_oversize,
  output logic              oversize_run
);

  logic             beat;
  logic             beat_first;
  logic             beat_last;
  logic [CNT_W-1:0] cnt_next;
  logic [2*DATA_W-1:0] fld_next;
  logic             fld_vld_next;
  logic             mm_now;
  logic             over_end;

  assign beat       = rx_valid;
  assign beat_first = rx_valid && rx_first;
  assign beat_last  = rx_valid && rx_last;

  lc_byte_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .beat     (beat),
    .first    (beat_first),
    .cnt_next (cnt_next)
  );

  lc_field_capture #(.CNT_W(CNT_W), .DATA_W(DATA_W), .FIELD_POS(FIELD_POS)) u_fld (
    .clk          (clk),
    .rst          (rst),
    .beat         (beat),
    .first        (beat_first),
    .cnt_next     (cnt_next),
    .data         (rx_data),
    .fld_next     (fld_next),
    .fld_vld_next (fld_vld_next)
  );

  lc_len_judge #(.CNT_W(CNT_W)) u_judge (
    .enable   (cfg_len_chk_en),
    .fld      (16'(fld_next)),
    .fld_vld  (fld_vld_next),
    .total    (cnt_next),
    .mismatch (mm_now)
  );

  lc_size_guard #(.CNT_W(CNT_W)) u_size (
    .clk      (clk),
    .rst      (rst),
    .beat     (beat),
    .first    (beat_first),
    .last     (beat_last),
    .huge_en  (cfg_huge_en),
    .max_len  (CNT_W'(cfg_max_len)),
    .cnt_next (cnt_next),
    .over_end (over_end),
    .run_flag (oversize_run)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      err_len_mismatch <= 1'b0;
      err_oversize     <= 1'b0;
    end else begin
      err_len_mismatch <= beat_last && mm_now;
      err_oversize     <= beat_last && over_end;
    end
  end

endmodule

// File: rtl/eth_rx_len_chk_checker.sv
module eth_rx_len_chk_checker (
  input logic clk,
  input logic rst,
  input logic rx_valid,
  input logic rx_first,
  input logic rx_last,
  input logic cfg_len_chk_en,
  input logic cfg_huge_en,
  input logic err_len_mismatch,
  input logic err_oversize,
  input logic oversize_run
);

  AST_MM_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    err_len_mismatch |-> $past(rx_valid && rx_last)); // R11

  AST_OV_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    err_oversize |-> $past(rx_valid && rx_last)); // R11

  AST_MM_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    err_len_mismatch |-> $past(cfg_len_chk_en)); // R2

  AST_OV_NOT_WHEN_HUGE: assert property (@(posedge clk) disable iff (rst)
    err_oversize |-> $past(!cfg_huge_en)); // R9

  AST_RUN_DROPS_AT_END: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_last) |=> !oversize_run); // R10

  AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (oversize_run && !(rx_valid && (rx_last || rx_first))) |=> oversize_run); // R10

  AST_RUN_GIVES_ERR: assert property (@(posedge clk) disable iff (rst)
    (oversize_run && rx_valid && rx_last && !rx_first) |=> err_oversize); // R8

endmodule

bind eth_rx_len_chk eth_rx_len_chk_checker u_chk (
  .clk              (clk),
  .rst              (rst),
  .rx_valid         (rx_valid),
  .rx_first         (rx_first),
  .rx_last          (rx_last),
  .cfg_len_chk_en   (cfg_len_chk_en),
  .cfg_huge_en      (cfg_huge_en),
  .err_len_mismatch (err_len_mismatch),
  .err_oversize     (err_oversize),
  .oversize_run     (oversize_run)
);

// File: tb/sim_eth_rx_len_chk.sv
module sim_eth_rx_len_chk;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_valid = 1'b0;
  logic        rx_first = 1'b0;
  logic        rx_last = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic        cfg_len_chk_en = 1'b1;
  logic        cfg_huge_en = 1'b0;
  logic [15:0] cfg_max_len = 16'd1518;
  logic        err_len_mismatch;
  logic        err_oversize;
  logic        oversize_run;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    logic mm;
    logic ov;
    string tag;
  } exp_t;

  exp_t sb_q[$];

  always #2 clk = ~clk;

  eth_rx_len_chk u0 (
    .clk              (clk),
    .rst              (rst),
    .rx_valid         (rx_valid),
    .rx_first         (rx_first),
    .rx_last          (rx_last),
    .rx_data          (rx_data),
    .cfg_len_chk_en   (cfg_len_chk_en),
    .cfg_huge_en      (cfg_huge_en),
    .cfg_max_len      (cfg_max_len),
    .err_len_mismatch (err_len_mismatch),
    .err_oversize     (err_oversize),
    .oversize_run     (oversize_run)
  );

  function automatic logic model_mm(int total, logic [15:0] fld, logic en);
    int want;
    if (!en) return 1'b0;
    if (total < 14) return 1'b1;
    if (fld >= 16'h0600) return 1'b0;
    if (fld > 16'd1500) return 1'b1;
    want = (fld < 16'd46) ? 46 : int'(fld);
    return (total - 18) != want;
  endfunction

  function automatic logic model_ov(int total, logic huge, logic [15:0] mx);
    int n;
    n = (total > 65535) ? 65535 : total;
    return !huge && (n > int'(mx));
  endfunction

  task automatic check(string tag, logic act, logic expv, string what);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, expv);
    end
  endtask

  task automatic send_frame(string tag, int total, logic [15:0] fld, bit drop_last, int gap_every);
    exp_t e;
    if (!drop_last) begin
      e.mm = model_mm(total, fld, cfg_len_chk_en);
      e.ov = model_ov(total, cfg_huge_en, cfg_max_len);
      e.tag = tag;
      sb_q.push_back(e);
    end
    for (int i = 0; i < total; i++) begin
      @(posedge clk); #1;
      rx_valid = 1'b1;
      rx_first = (i == 0);
      rx_last  = (i == total - 1) && !drop_last;
      rx_data  = (i == 12) ? fld[15:8] : (i == 13) ? fld[7:0] : 8'(i);
      if (gap_every > 0 && (i % gap_every) == gap_every - 1 && i != total - 1) begin
        @(posedge clk); #1;
        rx_valid = 1'b0;
        rx_first = 1'b0;
        rx_last  = 1'b0;
      end
    end
    @(posedge clk); #1;
    rx_valid = 1'b0;
    rx_first = 1'b0;
    rx_last  = 1'b0;
  endtask

  // Monitor / scoreboard
  bit pend = 1'b0;
  int mcnt = 0;
  bit mrun = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (pend) begin
        exp_t e;
        if (sb_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R11 unexpected end of frame actual=1 expected=0");
        end else begin
          e = sb_q.pop_front();
          check(e.tag, err_len_mismatch, e.mm, "err_len_mismatch");
          check(e.tag, err_oversize, e.ov, "err_oversize");
        end
      end else begin
        check("R11", err_len_mismatch, 1'b0, "err_len_mismatch outside end");
        check("R11", err_oversize, 1'b0, "err_oversize outside end");
      end
      check("R10", oversize_run, mrun, "oversize_run");
      pend = rx_valid && rx_last;
      if (rx_valid) begin
        if (rx_first) begin
          mcnt = 1;
          mrun = 1'b0;
        end else if (mcnt < 65535) begin
          mcnt++;
        end
        if (rx_last) mrun = 1'b0;
        else if (!cfg_huge_en && mcnt > int'(cfg_max_len)) mrun = 1'b1;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R13", err_len_mismatch, 1'b0, "reset mismatch");
    check("R13", err_oversize, 1'b0, "reset oversize");
    check("R13", oversize_run, 1'b0, "reset run");
    @(posedge clk); #1;
    rst = 1'b0;
    repeat (2) @(posedge clk);

    cfg_len_chk_en = 1'b1; cfg_huge_en = 1'b0; cfg_max_len = 16'd1518;
    send_frame("R3", 64, 16'd46, 0, 0);
    send_frame("R3", 100, 16'd82, 0, 0);
    send_frame("R3", 101, 16'd82, 0, 0);
    send_frame("R3", 1518, 16'd1500, 0, 0);
    send_frame("R4", 64, 16'd10, 0, 0);
    send_frame("R4", 30, 16'd10, 0, 0);
    send_frame("R5", 80, 16'h0800, 0, 0);
    send_frame("R5", 70, 16'h0600, 0, 0);
    send_frame("R6", 80, 16'h05E0, 0, 0);
    send_frame("R6", 80, 16'h05DD, 0, 0);
    send_frame("R7", 10, 16'h0000, 0, 0);
    send_frame("R7", 1, 16'h0000, 0, 0);
    cfg_len_chk_en = 1'b0;
    send_frame("R2", 101, 16'd82, 0, 0);
    send_frame("R2", 10, 16'h05E0, 0, 0);
    cfg_len_chk_en = 1'b1;

    send_frame("R1", 20, 16'd82, 1, 0);
    send_frame("R1", 64, 16'd46, 0, 5);
    send_frame("R1", 100, 16'd82, 0, 3);

    cfg_max_len = 16'd100;
    send_frame("R8", 100, 16'd82, 0, 0);
    send_frame("R8", 101, 16'd83, 0, 0);
    send_frame("R10", 140, 16'h0800, 0, 4);
    send_frame("R10", 64, 16'd46, 0, 0);
    cfg_huge_en = 1'b1;
    send_frame("R9", 200, 16'h0800, 0, 0);
    cfg_huge_en = 1'b0;

    cfg_len_chk_en = 1'b0;
    cfg_max_len = 16'hFFFF;
    send_frame("R12", 65540, 16'h0800, 0, 0);
    cfg_max_len = 16'hFFFE;
    send_frame("R12", 65540, 16'h0800, 0, 0);

    repeat (4) @(posedge clk);
    check("R11", sb_q.size() == 0, 1'b1, "scoreboard drained");
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule